// File: doc/BRIEF.md
# Serial Successive-Approximation Converter Core

This block holds the digital half of an 8-bit successive-approximation converter. It is driven by a host over a four-wire serial link: an active-low chip select, a serial clock, a data input and a data output with its own drive enable. The analog front end stays outside the block. The front end receives the trial code and the multiplexer selects from this block and returns one comparator bit. That bit is high when the selected input is at or above the trial level.

After chip select falls, the block waits for a start bit on the data input. It then takes a four-bit channel address and decodes it into one-hot positive and negative input selects for an eight-input multiplexer. A settle slot of one clock period follows, during which the data output drives a zero. The block then runs the binary search one bit per clock and sends each decision out as it is made, most significant bit first. Once the last decision is out, the result is sent a second time, least significant bit first. The two streams share the least significant bit. Raising chip select aborts a transfer at any point and clears every register.

Top module: `sar_serial_core`

## Requirements
- R1: While cs_n is high, every register is cleared: dout_en, dout and busy are 0, trial is 0, and sel_pos, sel_neg and neg_com are all 0.
- R2: With cs_n low, din is sampled on rising sclk edges. Leading zeros are ignored and the first 1 is the start bit. Until the address is complete, dout_en stays 0 and no select is active.
- R3: The four bits after the start bit are, in arrival order: sgl (1 = single-ended), odd, s1, s0. In single-ended mode, sel_pos is one-hot at index p = odd + 2*s0 + 4*s1, sel_neg is 0 and neg_com is 1.
- R4: In differential mode (sgl = 0), sel_pos is one-hot at p = odd + 2*s0 + 4*s1, sel_neg is one-hot at p XOR 1 (the other member of the adjacent pair), and neg_com is 0.
- R5: On the falling edge that follows the rising edge capturing s0, busy and dout_en rise and dout drives 0. From that point until cs_n rises, din has no effect: the selects keep their decoded values.
- R6: The trial code is 0x80 during the settle slot. Each decision keeps the current trial bit when cmp_hi is 1 and clears it otherwise, then sets the next lower bit. After the eighth decision, trial holds the final result, which is the largest code not above the input.
- R7: On each of the 8 falling edges after the settle slot, dout carries the decision just made, most significant bit first.
- R8: busy stays high through the eighth decision and falls on the next rising edge.
- R9: On the 7 falling edges after the last decision, dout carries result bits 1 through 7 in that order. dout then stays 0, still driven, until cs_n rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| sclk | input | 1 | Serial clock; address on rising edges, data out on falling edges |
| cs_n | input | 1 | Active-low select; high level clears the block asynchronously |
| din | input | 1 | Serial start bit and channel address |
| cmp_hi | input | 1 | Comparator: selected input at or above the trial level |
| dout | output | 1 | Serial result bit |
| dout_en | output | 1 | Drive enable for dout; 0 means high impedance |
| busy | output | 1 | Conversion in progress |
| trial | output | 8 | Trial code to the reference ladder |
| sel_pos | output | 8 | One-hot positive multiplexer input |
| sel_neg | output | 8 | One-hot negative multiplexer input (differential mode) |
| neg_com | output | 1 | Negative side taken from the common input |

## Verification
The decoded selects are due right after the rising edge that captures s0, and busy rises on the falling edge after that. Counting falling edges from that point, edge 0 is the settle zero, edges 1 to 8 carry the MSB-first decisions, and edges 9 to 15 carry the LSB-first bits. busy is due low on the rising edge between edges 8 and 9. The bench drives din a quarter period after each falling edge. It samples falling-edge outputs a quarter period after their edge and rising-edge outputs a quarter period after theirs, so each sample lands at the exact edge count above and away from any clock edge.

// File: rtl/sar_serial_core.sv
module sar_serial_core #(
  parameter int WIDTH = 8
) (
  input  logic             sclk,
  input  logic             cs_n,
  input  logic             din,
  input  logic             cmp_hi,
  output logic             dout,
  output logic             dout_en,
  output logic             busy,
  output logic [WIDTH-1:0] trial,
  output logic [7:0]       sel_pos,
  output logic [7:0]       sel_neg,
  output logic             neg_com
);
  localparam int STEP_W   = $clog2(2*WIDTH + 1);
  localparam int LAST_DEC = WIDTH + 1;
  localparam int TAIL     = 2*WIDTH;

  logic              started, armed, done_r;
  logic [1:0]        acnt;
  logic [3:0]        addr;
  logic [STEP_W-1:0] fstep;
  logic [WIDTH-1:0]  sar;
  logic              dout_r, en_r, busy_set;
  logic [2:0]        pos_idx;

  // rising edge: start hunt and address capture
  always_ff @(posedge sclk or posedge cs_n) begin
    if (cs_n) begin
      started <= 1'b0;
      armed   <= 1'b0;
      acnt    <= '0;
      addr    <= '0;
      done_r  <= 1'b0;
    end else begin
      if (!started) begin
        started <= din;
      end else if (!armed) begin
        addr <= {addr[2:0], din};
        acnt <= acnt + 2'd1;
        if (acnt == 2'd3) armed <= 1'b1;
      end
      if (fstep == STEP_W'(LAST_DEC)) done_r <= 1'b1;
    end
  end

  // falling edge: settle slot, decisions, serial output
  always_ff @(negedge sclk or posedge cs_n) begin
    if (cs_n) begin
      fstep    <= '0;
      sar      <= '0;
      dout_r   <= 1'b0;
      en_r     <= 1'b0;
      busy_set <= 1'b0;
    end else if (armed) begin
      if (fstep != STEP_W'(TAIL)) fstep <= fstep + 1'b1;
      if (fstep == '0) begin
        en_r     <= 1'b1;
        busy_set <= 1'b1;
        dout_r   <= 1'b0;
        sar      <= {1'b1, {(WIDTH-1){1'b0}}};
      end else if (int'(fstep) <= WIDTH) begin
        for (int i = 0; i < WIDTH; i++) begin
          if (i == WIDTH - int'(fstep))          sar[i] <= cmp_hi;
          else if (i == WIDTH - 1 - int'(fstep)) sar[i] <= 1'b1;
        end
        dout_r <= cmp_hi;
      end else begin
        dout_r <= 1'b0;
        for (int i = 1; i < WIDTH; i++)
          if (int'(fstep) == WIDTH + i) dout_r <= sar[i];
      end
    end
  end

  assign pos_idx = {addr[1], addr[0], addr[2]};
  assign sel_pos = armed ? (8'd1 << pos_idx) : 8'd0;
  assign sel_neg = (armed && !addr[3]) ? (8'd1 << (pos_idx ^ 3'd1)) : 8'd0;
  assign neg_com = armed & addr[3];
  assign trial   = sar;
  assign dout    = dout_r;
  assign dout_en = en_r;
  assign busy    = busy_set & ~done_r;

  AST_IDLE_NO_DRIVE: assert property (@(posedge sclk) disable iff (cs_n)
    !armed |-> (!dout_en && !busy)); // R2
  AST_BUSY_DRIVES: assert property (@(posedge sclk) disable iff (cs_n)
    busy |-> dout_en); // R5
  AST_ADDR_FROZEN: assert property (@(posedge sclk) disable iff (cs_n)
    armed |=> ($stable(addr) && armed)); // R5
  AST_DONE_NOT_BUSY: assert property (@(posedge sclk) disable iff (cs_n)
    done_r |=> !busy); // R8
  AST_TAIL_LOW: assert property (@(negedge sclk) disable iff (cs_n)
    (fstep == STEP_W'(TAIL)) |=> (!dout && dout_en)); // R9
endmodule

// File: tb/sar_serial_core_bench.sv
module sar_serial_core_bench;
  logic       sclk = 1'b0;
  logic       cs_n = 1'b1;
  logic       din  = 1'b0;
  logic [7:0] vin  = 8'd0;
  logic       cmp_hi, dout, dout_en, busy, neg_com;
  logic [7:0] trial, sel_pos, sel_neg;
  int vectors = 0;
  int fails   = 0;
  bit finished = 1'b0;

  always #4 sclk = ~sclk;

  assign cmp_hi = (vin >= trial);

  sar_serial_core u_sar_serial_core (
    .sclk(sclk), .cs_n(cs_n), .din(din), .cmp_hi(cmp_hi),
    .dout(dout), .dout_en(dout_en), .busy(busy), .trial(trial),
    .sel_pos(sel_pos), .sel_neg(sel_neg), .neg_com(neg_com)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic chk_idle(input string req);
    chk(req, {29'd0, dout_en, dout, busy}, 32'd0);
    chk(req, {8'd0, trial, sel_pos, sel_neg}, 32'd0);
    chk(req, {31'd0, neg_com}, 32'd0);
  endtask

  task automatic chk_sel(input bit sgl, input bit odd, input bit s1, input bit s0);
    int p;
    p = odd + 2*s0 + 4*s1;
    if (sgl) begin
      chk("R3 sel_pos", {24'd0, sel_pos}, 32'd1 << p);
      chk("R3 sel_neg/neg_com", {23'd0, neg_com, sel_neg}, 32'h100);
    end else begin
      chk("R4 sel_pos", {24'd0, sel_pos}, 32'd1 << p);
      chk("R4 sel_neg/neg_com", {23'd0, neg_com, sel_neg}, 32'd1 << (p ^ 1));
    end
  endtask

  task automatic run_conv(input bit sgl, input bit odd, input bit s1, input bit s0,
                          input logic [7:0] v, input int nz);
    logic [4:0] hdr;
    hdr = {1'b1, sgl, odd, s1, s0};
    vin = v;
    @(negedge sclk); #2;
    chk_idle("R1 idle");
    for (int j = 0; j < nz + 5; j++) begin
      if (j == 0) cs_n = 1'b0; else begin @(negedge sclk); #2; end
      din = (j < nz) ? 1'b0 : hdr[4 - (j - nz)];
      @(posedge sclk); #2;
      if (j < nz + 4)
        chk("R2 hunt/address", {15'd0, dout_en, busy, sel_pos, sel_neg}, 32'd0);
    end
    chk_sel(sgl, odd, s1, s0);
    chk("R5 busy before settle edge", {31'd0, busy}, 32'd0);
    for (int s = 0; s < 20; s++) begin
      @(negedge sclk); #2;
      din = ~din;
      if (s == 0) begin
        chk("R5 settle", {29'd0, busy, dout_en, dout}, 32'd6);
        chk("R6 first trial", {24'd0, trial}, 32'h80);
      end else if (s <= 8) begin
        chk("R7 msb-first bit", {31'd0, dout}, {31'd0, v[8 - s]});
        chk("R8 busy during decisions", {30'd0, busy, dout_en}, 32'd3);
        if (s == 8) begin
          chk("R6 final result", {24'd0, trial}, {24'd0, v});
          @(posedge sclk); #2;
          chk("R8 busy falls", {31'd0, busy}, 32'd0);
        end
      end else if (s < 16) begin
        chk("R9 lsb-first bit", {31'd0, dout}, {31'd0, v[s - 8]});
      end else begin
        chk("R9 tail low", {30'd0, dout_en, dout}, 32'd2);
        chk_sel(sgl, odd, s1, s0);
      end
    end
    @(negedge sclk); #2;
    cs_n = 1'b1;
    #1;
    chk_idle("R1 cleared on deselect");
  endtask

  initial begin
    repeat (2) @(posedge sclk);
    for (int v = 0; v < 256; v++) begin
      logic [3:0] a;
      a = v[3:0] ^ v[7:4];
      run_conv(a[3], a[2], a[1], a[0], v[7:0], v % 3);
    end
    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge sclk);
    if (!finished) begin
      vectors++;
      fails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end
endmodule